// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when an SDRAM must be refreshed and drives the command strobes that do it. A prescaler makes a count tick at a rate set by a 3-bit clock-select field. A refresh timer counts these ticks. When the timer equals a programmed compare value, the timer wraps to zero and a refresh request is latched. The sequencer turns each request into a burst of one to eight refreshes.

Each refresh in a burst is a precharge-all command, an optional gap of idle cycles, the refresh command itself, and a recovery window in which no command is issued. The scheduler does not start a burst while the normal access path reports that an access is in progress. It holds `rfshBusy` high for the whole burst, so the access path stays off the bus. If the enable bit and the mode bit are both set, the block stops scheduling bursts and holds the self-refresh request instead.

Top module: `refresh_sched`

## Requirements
- R1: Auto-refresh runs only while `cfgEnable`=1 and `cfgSelfMode`=0. While `cfgEnable`=0, no command output and no `rfshBusy` is ever raised, even when the timer matches.
- R2: When `cfgEnable`=1 and `cfgSelfMode`=1 and no access is in progress, `cmdSelfRefresh` and `rfshBusy` rise one cycle later and stay high while both bits stay set, with no other command. They fall one cycle after either bit clears.
- R3: When `cfgClkSel`=0 the timer holds its value. When a source is selected again, the timer continues from the held value and is not cleared.
- R4: When `cfgClkSel`=k, for k from 1 to 7, the timer advances by exactly one every 2^(k-1) clock cycles.
- R5: On a tick where the timer equals `cfgCompare`, the timer becomes 0 and a request is latched. If the block is idle and no access is in progress, `cmdPall` is high in the cycle after the timer first shows 0.
- R6: One request produces `cfgRepeat`+1 refreshes back to back. Each refresh is one `cmdPall` cycle followed by one `cmdRef` cycle.
- R7: Let d be `cfgPreDelay`. `cmdRef` comes d+1 cycles after `cmdPall`. `cmdNop` is high in each of the d cycles between the two, and only there, so it appears only when the delay setting is 2 cycles or more.
- R8: Let r be `cfgRecDelay`. After `cmdRef`, r+1 cycles pass with every command output low. The next refresh of the burst then starts with `cmdPall` in the following cycle.
- R9: `rfshBusy` is high from the first `cmdPall` cycle through the last recovery cycle of the final refresh. That is (`cfgRepeat`+1)·(3+d+r) cycles, after which it falls.
- R10: While `accessBusy` is high and the block is idle, no burst starts. `cmdPall` is high in the cycle after the first cycle in which `accessBusy` is low with a request pending.
- R11: A match that occurs during a burst is kept as one pending request. After the burst, `rfshBusy` is low for exactly one cycle and then the next burst begins with `cmdPall`.
- R12: After reset, the timer is 0 and all command outputs and `rfshBusy` are low. At most one of `cmdPall`, `cmdNop`, `cmdRef`, `cmdSelfRefresh` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSelfMode | input | 1 | 0 selects auto-refresh, 1 selects self-refresh when enabled |
| cfgEnable | input | 1 | Refresh enable |
| cfgClkSel | input | SEL_W | Tick source: 0 stops the timer, k gives one tick every 2^(k-1) cycles |
| cfgCompare | input | CNT_W | Timer compare value |
| cfgRepeat | input | RPT_W | Refreshes per request, minus one |
| cfgPreDelay | input | DLY_W | Precharge-to-refresh spacing, minus one |
| cfgRecDelay | input | DLY_W | Recovery cycles after refresh, minus one |
| accessBusy | input | 1 | Normal access path is mid-access |
| timerNow | output | CNT_W | Current refresh timer value |
| rfshBusy | output | 1 | Refresh owns the SDRAM bus |
| cmdPall | output | 1 | Precharge-all command strobe |
| cmdNop | output | 1 | NOP strobe in the precharge gap |
| cmdRef | output | 1 | Auto-refresh command strobe |
| cmdSelfRefresh | output | 1 | Self-refresh held request |

## Verification
A wrong sequencer state shows at once as a command pattern that drifts from the (3+d+r)-cycle frame. It may be a misplaced `cmdRef`, a `cmdNop` where d is 0, or a `rfshBusy` edge one cycle off, and all of these appear within the first refresh of a burst. A wrong burst-count or pending state shows only at the end of a burst, as a burst that is too short or too long, or as a missing follow-up burst. A prescaler or timer fault shows on `timerNow` within 2^(k-1) cycles. A wrong wrap point moves the first `cmdPall` away from the cycle after the timer shows zero.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PALL,
    ST_PGAP,
    ST_REF,
    ST_RECOV,
    ST_SELF
  } rfshState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic takeReq;      // accept the pending request, load the burst count
    logic loadPre;      // load the precharge gap length
    logic loadRec;      // load the recovery length
    logic countDown;    // decrement the delay counter
    logic nextRefresh;  // one refresh of the burst is finished
  } rfshStrobe_t;

endpackage

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3,
  parameter int RPT_W = 3,
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  input  logic [CNT_W-1:0] compareVal,
  input  logic             autoOn,
  input  logic [RPT_W-1:0] repeatCnt,
  input  logic [DLY_W-1:0] preDelay,
  input  logic [DLY_W-1:0] recDelay,
  input  rfshStrobe_t      strobe,
  output logic [CNT_W-1:0] cntQ,
  output logic             reqPending,
  output logic             gapLast,
  output logic             burstDone
);

  localparam int PRE_W  = (1 << SEL_W) - 2;
  localparam int DCNT_W = DLY_W + 1;

  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W:0]    maskWide;
  logic              tick;
  logic              matchHit;
  logic [RPT_W-1:0]  burstLeft;
  logic [DCNT_W-1:0] dlyCnt;

  // Free-running prescaler; select k ticks when the low k-1 bits are all ones
  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    maskWide = ((PRE_W+1)'(1) << (clkSel - 1'b1)) - (PRE_W+1)'(1);
    if (clkSel == '0) tick = 1'b0;
    else              tick = ((preCnt & maskWide[PRE_W-1:0]) == maskWide[PRE_W-1:0]);
  end

  assign matchHit = tick && (cntQ == compareVal);

  always_ff @(posedge clk) begin
    if (!rstN)          cntQ <= '0;
    else if (matchHit)  cntQ <= '0;
    else if (tick)      cntQ <= cntQ + 1'b1;
  end

  // A new match wins over the clear, so a request is never lost
  always_ff @(posedge clk) begin
    if (!rstN) reqPending <= 1'b0;
    else       reqPending <= autoOn && (matchHit || (reqPending && !strobe.takeReq));
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   burstLeft <= '0;
    else if (strobe.takeReq)     burstLeft <= repeatCnt;
    else if (strobe.nextRefresh) burstLeft <= burstLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 dlyCnt <= '0;
    else if (strobe.loadPre)   dlyCnt <= {1'b0, preDelay};
    else if (strobe.loadRec)   dlyCnt <= {1'b0, recDelay} + 1'b1;
    else if (strobe.countDown) dlyCnt <= dlyCnt - 1'b1;
  end

  assign gapLast   = (dlyCnt == DCNT_W'(1));
  assign burstDone = (burstLeft == '0);

  AST_HOLD_UNSELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == '0) |=> $stable(cntQ)); // R3
  AST_WRAP_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == SEL_W'(1) && cntQ == compareVal) |=> (cntQ == '0)); // R5
  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (autoOn && reqPending && !strobe.takeReq) |=> reqPending); // R11

endmodule

// File: rtl/rfsh_control.sv
module rfsh_control
  import rfsh_pkg::*;
#(
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selfOn,
  input  logic             accessBusy,
  input  logic [DLY_W-1:0] preDelay,
  input  logic             reqPending,
  input  logic             gapLast,
  input  logic             burstDone,
  output rfshStrobe_t      strobe,
  output logic             cmdPall,
  output logic             cmdNop,
  output logic             cmdRef,
  output logic             cmdSelf,
  output logic             busy
);

  rfshState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (!accessBusy) begin
          if (selfOn) begin
            stateNext = ST_SELF;
          end else if (reqPending) begin
            stateNext      = ST_PALL;
            strobe.takeReq = 1'b1;
          end
        end
      end
      ST_PALL: begin
        if (preDelay == '0) begin
          stateNext = ST_REF;
        end else begin
          stateNext      = ST_PGAP;
          strobe.loadPre = 1'b1;
        end
      end
      ST_PGAP: begin
        if (gapLast) stateNext = ST_REF;
        else         strobe.countDown = 1'b1;
      end
      ST_REF: begin
        stateNext      = ST_RECOV;
        strobe.loadRec = 1'b1;
      end
      ST_RECOV: begin
        if (!gapLast) begin
          strobe.countDown = 1'b1;
        end else if (burstDone) begin
          stateNext = ST_IDLE;
        end else begin
          stateNext          = ST_PALL;
          strobe.nextRefresh = 1'b1;
        end
      end
      ST_SELF: begin
        if (!selfOn) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign cmdPall = (state == ST_PALL);
  assign cmdNop  = (state == ST_PGAP);
  assign cmdRef  = (state == ST_REF);
  assign cmdSelf = (state == ST_SELF);
  assign busy    = (state != ST_IDLE);

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdPall, cmdNop, cmdRef, cmdSelf})); // R12
  AST_WAIT_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && accessBusy) |=> !cmdPall); // R10
  AST_DIRECT_REF: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPall && preDelay == '0) |=> cmdRef); // R7
  AST_SELF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdSelf && selfOn) |=> cmdSelf); // R2
  AST_BUSY_COVERS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPall || cmdRef || cmdNop) |-> busy); // R9

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import rfsh_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3,
  parameter int RPT_W = 3,
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSelfMode,
  input  logic             cfgEnable,
  input  logic [SEL_W-1:0] cfgClkSel,
  input  logic [CNT_W-1:0] cfgCompare,
  input  logic [RPT_W-1:0] cfgRepeat,
  input  logic [DLY_W-1:0] cfgPreDelay,
  input  logic [DLY_W-1:0] cfgRecDelay,
  input  logic             accessBusy,
  output logic [CNT_W-1:0] timerNow,
  output logic             rfshBusy,
  output logic             cmdPall,
  output logic             cmdNop,
  output logic             cmdRef,
  output logic             cmdSelfRefresh
);

  rfshStrobe_t strobe;
  logic        autoOn, selfOn;
  logic        reqPending, gapLast, burstDone;

  assign autoOn = cfgEnable && !cfgSelfMode;
  assign selfOn = cfgEnable &&  cfgSelfMode;

  rfsh_datapath #(
    .CNT_W(CNT_W), .SEL_W(SEL_W), .RPT_W(RPT_W), .DLY_W(DLY_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .clkSel(cfgClkSel), .compareVal(cfgCompare),
    .autoOn(autoOn), .repeatCnt(cfgRepeat), .preDelay(cfgPreDelay),
    .recDelay(cfgRecDelay), .strobe(strobe), .cntQ(timerNow),
    .reqPending(reqPending), .gapLast(gapLast), .burstDone(burstDone)
  );

  rfsh_control #(.DLY_W(DLY_W)) u_control (
    .clk(clk), .rstN(rstN), .selfOn(selfOn), .accessBusy(accessBusy),
    .preDelay(cfgPreDelay), .reqPending(reqPending), .gapLast(gapLast),
    .burstDone(burstDone), .strobe(strobe), .cmdPall(cmdPall),
    .cmdNop(cmdNop), .cmdRef(cmdRef), .cmdSelf(cmdSelfRefresh),
    .busy(rfshBusy)
  );

endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgSelfMode = 1'b0, cfgEnable = 1'b0;
  logic [2:0] cfgClkSel = '0;
  logic [7:0] cfgCompare = '0;
  logic [2:0] cfgRepeat = '0;
  logic [1:0] cfgPreDelay = '0, cfgRecDelay = '0;
  logic       accessBusy = 1'b0;
  logic [7:0] timerNow;
  logic       rfshBusy, cmdPall, cmdNop, cmdRef, cmdSelfRefresh;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  refresh_sched u_refresh_sched (
    .clk(clk), .rstN(rstN), .cfgSelfMode(cfgSelfMode), .cfgEnable(cfgEnable),
    .cfgClkSel(cfgClkSel), .cfgCompare(cfgCompare), .cfgRepeat(cfgRepeat),
    .cfgPreDelay(cfgPreDelay), .cfgRecDelay(cfgRecDelay), .accessBusy(accessBusy),
    .timerNow(timerNow), .rfshBusy(rfshBusy), .cmdPall(cmdPall), .cmdNop(cmdNop),
    .cmdRef(cmdRef), .cmdSelfRefresh(cmdSelfRefresh)
  );

  function automatic int outVec();
    return {27'd0, rfshBusy, cmdSelfRefresh, cmdRef, cmdNop, cmdPall};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset(input bit en, input bit mode, input int sel, input int cmp,
                         input int rep, input int d, input int r, input bit acc);
    @(negedge clk);
    rstN = 1'b0;
    cfgEnable = en; cfgSelfMode = mode; cfgClkSel = 3'(sel); cfgCompare = 8'(cmp);
    cfgRepeat = 3'(rep); cfgPreDelay = 2'(d); cfgRecDelay = 2'(r); accessBusy = acc;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Burst frame sweep: R5..R9 and R12, pattern computed from d, r, rep
  task automatic runCfg(input int d, input int r, input int rep);
    int prev;
    int len;
    int n;
    int exp;
    bit seen;
    len = 3 + d + r;
    n = rep + 1;
    doReset(1, 0, 1, 100, rep, d, r, 0);
    prev = timerNow;
    seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (prev == 100 && timerNow == 0) seen = 1;
      prev = timerNow;
    end
    chk(seen, "R5 timer wrap", int'(timerNow), 0);
    for (int k = 0; k <= n * len; k++) begin
      @(negedge clk);
      if (k < n * len) begin
        int p;
        p = k % len;
        exp = 16 | ((p == 0) ? 1 : 0) | ((p >= 1 && p <= d) ? 2 : 0)
                 | ((p == d + 1) ? 4 : 0);
      end else begin
        exp = 0;
      end
      // R6 R7 R8 R9 R12: {busy,self,ref,nop,pall}
      chk(outVec() == exp, $sformatf("R6/R7/R8/R9 d=%0d r=%0d rep=%0d k=%0d", d, r, rep, k),
          outVec(), exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    int v0;
    bit bad;

    // R12 reset state
    doReset(1, 0, 1, 3, 0, 0, 0, 0);
    rstN = 1'b0;
    @(negedge clk);
    chk(outVec() == 0, "R12 reset outputs", outVec(), 0);
    chk(timerNow == 0, "R12 reset timer", int'(timerNow), 0);

    // Near-exhaustive frame sweep
    for (int d = 0; d < 4; d++)
      for (int r = 0; r < 4; r++) begin
        runCfg(d, r, 0);
        runCfg(d, r, 1);
      end
    runCfg(3, 3, 7);
    runCfg(0, 0, 7);

    // R4 tick rates
    for (int k = 1; k < 8; k++) begin
      doReset(0, 0, k, 255, 0, 0, 0, 0);
      @(negedge clk);
      v0 = timerNow;
      repeat (128) @(negedge clk);
      chk(int'(timerNow) - v0 == (128 >> (k - 1)), $sformatf("R4 sel=%0d", k),
          int'(timerNow) - v0, 128 >> (k - 1));
    end

    // R3 hold and resume
    doReset(0, 0, 1, 255, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    cfgClkSel = 3'd0;
    @(negedge clk);
    v = timerNow;
    repeat (20) @(negedge clk);
    chk(timerNow == 8'(v), "R3 hold", int'(timerNow), v);
    cfgClkSel = 3'd1;
    @(negedge clk);
    chk(timerNow == 8'(v + 1), "R3 resume", int'(timerNow), v + 1);

    // R1 disabled: matches produce nothing
    doReset(0, 0, 1, 3, 0, 0, 0, 0);
    bad = 0;
    repeat (60) begin
      @(negedge clk);
      if (outVec() != 0) bad = 1;
    end
    chk(!bad, "R1 disabled silent", int'(bad), 0);

    // R2 self-refresh hold and release
    doReset(1, 0, 0, 3, 0, 0, 0, 0);
    @(negedge clk);
    cfgSelfMode = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(outVec() == 24, "R2 self held", outVec(), 24);
    end
    cfgSelfMode = 1'b0;
    @(negedge clk);
    chk(outVec() == 0, "R2 self release", outVec(), 0);

    // R10 access in progress delays the burst
    doReset(1, 0, 1, 10, 0, 0, 0, 1);
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (outVec() != 0) bad = 1;
    end
    chk(!bad, "R10 blocked while access", int'(bad), 0);
    accessBusy = 1'b0;
    @(negedge clk);
    chk(cmdPall == 1'b1, "R10 start after access", int'(cmdPall), 1);

    // R11 match during burst is kept
    doReset(1, 0, 1, 2, 7, 3, 3, 0);
    v = 0;
    for (int i = 0; i < 50 && v == 0; i++) begin
      @(negedge clk);
      if (rfshBusy) v = 1;
    end
    for (int i = 0; i < 200 && v == 1; i++) begin
      @(negedge clk);
      if (!rfshBusy) v = 2;
    end
    chk(v == 2 && outVec() == 0, "R11 busy gap", outVec(), 0);
    @(negedge clk);
    chk(outVec() == 17, "R11 next burst", outVec(), 17);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule